// File: doc/BRIEF.md
# Double-Buffered Bit-Plane Frame Serializer

The block takes a host stream of 12-bit words and packs each group of three into one 30-bit record made of a 10-bit destination address, a 19-bit data field and a parity bit. The 20-bit stored word is the data field with an odd parity bit below it. It is written into one of two storage banks, at the location given by the destination address. A frame tick hands the bank that has just been filled to the read side, and the host goes on to fill the other bank.

The read side sends the handed-off bank out as a serial bit stream. It works one bit plane at a time, from the top plane down. Within a plane it takes nibbles of four consecutive locations in ascending order. Each bit is cleared in storage as it is fetched. A destination that gets no new word in the next frame therefore sends an all-zero no-op word.

Framing is checked on the way in. A group that does not begin with a start flag, or that a new start flag cuts short, is dropped and an error pulse is raised. A last-destination flag in the third word closes the frame on the host side: the block stops accepting host words until the next frame tick is taken.

Top module: `frame_plane_serializer`

## Requirements
- R1: Host word fields for one record. Bit 11 is the start flag and must be 1 in the first word and 0 in the second and third. First word bits 9..0 carry stored bits 19..10. Second word bits 8..0 carry stored bits 9..1. Third word bits 9..0 carry the destination address, and third word bit 10 is the last-destination flag. A host word is taken in any cycle where host_valid and host_ready are both 1.
- R2: Bit 0 of every stored word is chosen so that the 20-bit word holds an odd number of ones.
- R3: A stored word goes to the location equal to the destination address. A record whose address is DEPTH or above is dropped, and a later record to the same address overwrites the earlier one.
- R4: A first word with bit 11 clear is dropped. A word with bit 11 set arriving as the second or third word drops the partial group and starts a new one. In both cases frame_err is 1 for exactly the cycle after the offending word is taken.
- R5: After a third word with bit 10 set is taken, host_ready is 0 from the next cycle until a frame tick is taken. A taken frame tick sets host_ready back to 1.
- R6: A taken frame tick swaps the two banks. The bank filled before the tick is read out, and later records go to the other bank.
- R7: The read-out sends bit planes 19 down to 0. Within a plane it sends locations 0 to READ_COUNT-1 in ascending order, as nibbles of four locations with the lowest address first. ser_valid stays 1 with no gap for all 20*READ_COUNT bits.
- R8: Only locations 0 to READ_COUNT-1 are sent. Locations from READ_COUNT to DEPTH-1 are neither sent nor cleared.
- R9: Each bit sent is cleared in its bank. A bank that is read out again with no new writes sends all zeros.
- R10: A frame tick that arrives while a read-out is still in progress is ignored. There is no swap, no restart, and host_ready is not released.
- R11: After reset, ser_valid is 0, frame_err is 0 and host_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| host_valid | input | 1 | Host word present |
| host_ready | output | 1 | Block accepts a host word |
| host_word | input | 12 | Host word with control bits 11 and 10 |
| frame_tick | input | 1 | Frame boundary request |
| ser_bit | output | 1 | Serial output bit |
| ser_valid | output | 1 | ser_bit carries stream data |
| frame_err | output | 1 | One-cycle pulse for a dropped group |

## Verification
The bench builds the block with DEPTH=32 and READ_COUNT=24. A whole read-out is then 480 bits, so three consecutive frames, covering both banks and the reuse of a bank after it has been cleared, fit in a short run. With these values an address of 26 is stored but never sent, and an address of 40 exceeds the depth and would alias onto location 8 if it were not dropped. The bench also lands a second group and an ignored frame tick in the middle of a read-out.

// File: rtl/fps_pkg.sv
package fps_pkg;
   localparam int HOST_W       = 12;
   localparam int ADDR_FIELD_W = 10;
   localparam int DATA_W       = 19;
   localparam int WORD_W       = DATA_W + 1;
   localparam int LANES        = 4;
   localparam int PLANE_W      = $clog2(WORD_W);
   localparam int LO_W         = HOST_W - 3;
   localparam int HI_W         = DATA_W - LO_W;

   function automatic logic odd_fill(input logic [DATA_W-1:0] d);
      return ~(^d);
   endfunction
endpackage

// File: rtl/fps_assembler.sv
module fps_assembler
   import fps_pkg::*;
(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    accept,
   input  logic [HOST_W-1:0]       host_word,
   output logic                    rec_valid,
   output logic [ADDR_FIELD_W-1:0] rec_addr,
   output logic [WORD_W-1:0]       rec_word,
   output logic                    last_accept,
   output logic                    frame_err
);
   typedef enum logic [1:0] {SLOT_HEAD, SLOT_MID, SLOT_TAIL} slot_t;

   slot_t             slot;
   logic [HI_W-1:0]   d_hi;
   logic [LO_W-1:0]   d_lo;
   logic              start_flag;
   logic              last_flag;

   assign start_flag  = host_word[HOST_W-1];
   assign last_flag   = host_word[HOST_W-2];
   assign last_accept = accept && (slot == SLOT_TAIL) && !start_flag && last_flag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot      <= SLOT_HEAD;
         d_hi      <= '0;
         d_lo      <= '0;
         rec_valid <= 1'b0;
         rec_addr  <= '0;
         rec_word  <= '0;
         frame_err <= 1'b0;
      end else begin
         rec_valid <= 1'b0;
         frame_err <= 1'b0;
         if (accept) begin
            if (start_flag) begin
               // a start flag always opens a fresh group; mid-group it truncates
               d_hi      <= host_word[HI_W-1:0];
               slot      <= SLOT_MID;
               frame_err <= (slot != SLOT_HEAD);
            end else begin
               case (slot)
                  SLOT_HEAD: frame_err <= 1'b1;
                  SLOT_MID: begin
                     d_lo <= host_word[LO_W-1:0];
                     slot <= SLOT_TAIL;
                  end
                  default: begin
                     rec_valid <= 1'b1;
                     rec_addr  <= host_word[ADDR_FIELD_W-1:0];
                     rec_word  <= {d_hi, d_lo, odd_fill({d_hi, d_lo})};
                     slot      <= SLOT_HEAD;
                  end
               endcase
            end
         end
      end
   end

   // R4: an orphan word at the head slot raises the error pulse
   assert_orphan_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && slot == SLOT_HEAD && !start_flag) |=> frame_err);

   // R4: a start flag inside a group raises the error pulse
   assert_cut_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && slot != SLOT_HEAD && start_flag) |=> frame_err);

   // R2: every emitted stored word has odd weight
   assert_odd_weight_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> ($countones(rec_word) % 2 == 1));
endmodule

// File: rtl/fps_bank.sv
module fps_bank
   import fps_pkg::*;
#(
   parameter int DEPTH  = 1024,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int ROWS   = DEPTH / LANES,
   localparam int ROW_W  = $clog2(ROWS)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [WORD_W-1:0]  wr_data,
   input  logic               rd_en,
   input  logic [ROW_W-1:0]   rd_row,
   input  logic [PLANE_W-1:0] rd_plane,
   output logic [LANES-1:0]   rd_bits
);
   localparam int ROW_BITS = LANES * WORD_W;
   localparam int IDX_W    = $clog2(ROW_BITS);

   logic [ROW_BITS-1:0] rows [ROWS];
   logic [ROW_W-1:0]    wr_row;
   logic [1:0]          wr_lane;

   assign wr_row  = wr_addr[ADDR_W-1:2];
   assign wr_lane = wr_addr[1:0];

   always_comb begin
      for (int l = 0; l < LANES; l++) begin
         rd_bits[l] = rows[rd_row][IDX_W'(l * WORD_W) + IDX_W'(rd_plane)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < ROWS; r++) rows[r] <= '0;
      end else begin
         if (rd_en) begin
            for (int l = 0; l < LANES; l++) begin
               rows[rd_row][IDX_W'(l * WORD_W) + IDX_W'(rd_plane)] <= 1'b0;
            end
         end
         if (wr_en) begin
            for (int l = 0; l < LANES; l++) begin
               if (wr_lane == 2'(l)) rows[wr_row][l*WORD_W +: WORD_W] <= wr_data;
            end
         end
      end
   end

   // R6: a bank is either being filled or being drained, never both at once
   assert_single_role_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && rd_en));
endmodule

// File: rtl/fps_reader.sv
module fps_reader
   import fps_pkg::*;
#(
   parameter int ROWS_READ = 252,
   parameter int ROW_W     = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LANES-1:0]   lane_bits,
   output logic               fetch,
   output logic [ROW_W-1:0]   fetch_row,
   output logic [PLANE_W-1:0] fetch_plane,
   output logic               ser_bit,
   output logic               ser_valid,
   output logic               busy
);
   localparam logic [ROW_W-1:0]   LAST_ROW  = ROW_W'(ROWS_READ - 1);
   localparam logic [PLANE_W-1:0] TOP_PLANE = PLANE_W'(WORD_W - 1);

   logic             fetching;
   logic [LANES-1:0] nib_buf;
   logic             buf_full;
   logic [LANES-1:0] shreg;
   logic [2:0]       sh_cnt;
   logic             load_sh;

   assign load_sh   = buf_full && (sh_cnt <= 3'd1);
   assign fetch     = fetching && (!buf_full || load_sh);
   assign ser_bit   = shreg[0];
   assign ser_valid = (sh_cnt != 3'd0);
   assign busy      = fetching || buf_full || ser_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fetching    <= 1'b0;
         fetch_row   <= '0;
         fetch_plane <= '0;
         nib_buf     <= '0;
         buf_full    <= 1'b0;
         shreg       <= '0;
         sh_cnt      <= '0;
      end else begin
         if (start) begin
            fetching    <= 1'b1;
            fetch_row   <= '0;
            fetch_plane <= TOP_PLANE;
         end else if (fetch) begin
            if (fetch_row == LAST_ROW) begin
               fetch_row <= '0;
               if (fetch_plane == '0) fetching <= 1'b0;
               else                   fetch_plane <= fetch_plane - 1'b1;
            end else begin
               fetch_row <= fetch_row + 1'b1;
            end
         end

         if (fetch) begin
            nib_buf  <= lane_bits;
            buf_full <= 1'b1;
         end else if (load_sh) begin
            buf_full <= 1'b0;
         end

         if (load_sh) begin
            shreg  <= nib_buf;
            sh_cnt <= 3'd4;
         end else if (sh_cnt != 3'd0) begin
            shreg  <= shreg >> 1;
            sh_cnt <= sh_cnt - 1'b1;
         end
      end
   end

   // R7: the stream only stops once nothing is left to send
   assert_no_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_valid) |-> (!fetching && !buf_full));

   // R6: a started read-out is in progress on the next cycle
   assert_start_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);
endmodule

// File: rtl/frame_plane_serializer.sv
module frame_plane_serializer
   import fps_pkg::*;
#(
   parameter int DEPTH      = 1024,
   parameter int READ_COUNT = 1008
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_valid,
   output logic              host_ready,
   input  logic [HOST_W-1:0] host_word,
   input  logic              frame_tick,
   output logic              ser_bit,
   output logic              ser_valid,
   output logic              frame_err
);
   localparam int ADDR_W    = $clog2(DEPTH);
   localparam int ROWS_READ = READ_COUNT / LANES;
   localparam int ROW_W     = $clog2(DEPTH / LANES);

   if (DEPTH % LANES != 0 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two and a multiple of the nibble size");
   end
   if (ADDR_W > ADDR_FIELD_W) begin : g_bad_field
      $error("DEPTH exceeds the destination address field");
   end
   if (READ_COUNT % LANES != 0 || READ_COUNT > DEPTH || ROWS_READ < 2) begin : g_bad_count
      $error("READ_COUNT must be a multiple of four, at least eight, and within DEPTH");
   end

   logic                    accept;
   logic                    rec_valid;
   logic [ADDR_FIELD_W-1:0] rec_addr;
   logic [WORD_W-1:0]       rec_word;
   logic                    last_accept;
   logic                    in_range;
   logic                    wr_en;
   logic                    sel;
   logic                    hold;
   logic                    busy;
   logic                    tick_ok;
   logic                    fetch;
   logic [ROW_W-1:0]        fetch_row;
   logic [PLANE_W-1:0]      fetch_plane;
   logic [LANES-1:0]        bank_bits [2];
   logic [LANES-1:0]        lane_bits;

   assign host_ready = !hold;
   assign accept     = host_valid && host_ready;
   assign tick_ok    = frame_tick && !busy;

   fps_assembler u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .accept      (accept),
      .host_word   (host_word),
      .rec_valid   (rec_valid),
      .rec_addr    (rec_addr),
      .rec_word    (rec_word),
      .last_accept (last_accept),
      .frame_err   (frame_err)
   );

   if (ADDR_W == ADDR_FIELD_W) begin : g_full_field
      assign in_range = 1'b1;
   end else begin : g_narrow_field
      assign in_range = (rec_addr[ADDR_FIELD_W-1:ADDR_W] == '0);
   end

   assign wr_en = rec_valid && in_range;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel  <= 1'b0;
         hold <= 1'b0;
      end else begin
         if (tick_ok) sel <= ~sel;
         if (last_accept)  hold <= 1'b1;
         else if (tick_ok) hold <= 1'b0;
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_bank
      fps_bank #(.DEPTH(DEPTH)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en && (sel == 1'(g))),
         .wr_addr  (rec_addr[ADDR_W-1:0]),
         .wr_data  (rec_word),
         .rd_en    (fetch && (sel != 1'(g))),
         .rd_row   (fetch_row),
         .rd_plane (fetch_plane),
         .rd_bits  (bank_bits[g])
      );
   end

   assign lane_bits = sel ? bank_bits[0] : bank_bits[1];

   fps_reader #(.ROWS_READ(ROWS_READ), .ROW_W(ROW_W)) u_rd (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (tick_ok),
      .lane_bits   (lane_bits),
      .fetch       (fetch),
      .fetch_row   (fetch_row),
      .fetch_plane (fetch_plane),
      .ser_bit     (ser_bit),
      .ser_valid   (ser_valid),
      .busy        (busy)
   );

   // R10: a tick during a read-out leaves the bank roles unchanged
   assert_tick_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_tick && busy) |=> $stable(sel));

   // R5: the last destination closes host intake on the next cycle
   assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      last_accept |=> !host_ready);

   // R5: a taken tick without a new last word reopens host intake
   assert_ready_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_ok && !last_accept) |=> host_ready);
endmodule

// File: tb/frame_plane_serializer_tb.sv
module frame_plane_serializer_tb;
   localparam int DEPTH  = 32;
   localparam int RCOUNT = 24;
   localparam int NBITS  = 20 * RCOUNT;
   localparam int NVEC   = 12;

   // {last, address, 19-bit data}; entries 0..7 frame A, 8..11 frame B
   localparam logic [29:0] VEC [NVEC] = '{
      {1'b0, 10'd0,  19'h7FFFF},
      {1'b0, 10'd5,  19'h12345},
      {1'b0, 10'd23, 19'h40001},
      {1'b0, 10'd26, 19'h7ABCD},
      {1'b0, 10'd40, 19'h55555},
      {1'b0, 10'd5,  19'h00F0F},
      {1'b0, 10'd12, 19'h00000},
      {1'b1, 10'd3,  19'h2AAAA},
      {1'b0, 10'd1,  19'h11111},
      {1'b0, 10'd22, 19'h7FFFE},
      {1'b0, 10'd8,  19'h30303},
      {1'b1, 10'd17, 19'h00001}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0;
   logic [11:0] host_word = '0;
   logic        frame_tick = 1'b0;
   logic        host_ready, ser_bit, ser_valid, frame_err;

   int checks = 0;
   int fails  = 0;
   int fill   = 0;
   logic [19:0] model [2][DEPTH];
   logic        cap [NBITS];
   int          cap_n;

   always #10 clk = ~clk;

   frame_plane_serializer #(.DEPTH(DEPTH), .READ_COUNT(RCOUNT)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_ready(host_ready),
      .host_word(host_word), .frame_tick(frame_tick), .ser_bit(ser_bit),
      .ser_valid(ser_valid), .frame_err(frame_err)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [19:0] stored(input logic [18:0] d);
      int ones = 0;
      for (int i = 0; i < 19; i++) ones += int'(d[i]);
      return {d, (ones % 2 == 0) ? 1'b1 : 1'b0};
   endfunction

   task automatic send_word(input logic [11:0] w);
      @(negedge clk);
      host_valid = 1'b1;
      host_word  = w;
      @(posedge clk);
      @(negedge clk);
      host_valid = 1'b0;
   endtask

   task automatic send_record(input logic [29:0] v);
      send_word({2'b10, v[18:9]});
      send_word({3'b000, v[8:0]});
      send_word({1'b0, v[29], v[28:19]});
      if (v[28:19] < DEPTH) model[fill][v[23:19]] = stored(v[18:0]);
   endtask

   task automatic pulse_tick();
      @(negedge clk);
      frame_tick = 1'b1;
      @(negedge clk);
      frame_tick = 1'b0;
   endtask

   task automatic collect();
      int waited = 0;
      cap_n = 0;
      while (!ser_valid && waited < 200) begin
         @(negedge clk);
         waited++;
      end
      while (ser_valid) begin
         if (cap_n < NBITS) cap[cap_n] = ser_bit;
         cap_n++;
         @(negedge clk);
      end
   endtask

   // mismatches of the captured stream against bank b of the model
   function automatic int stream_diff(input int b);
      int bad = 0;
      for (int k = 0; k < NBITS; k++) begin
         if (cap[k] !== model[b][k % RCOUNT][19 - k / RCOUNT]) bad++;
      end
      return bad;
   endfunction

   function automatic logic [19:0] word_at(input int a);
      logic [19:0] w;
      for (int p = 0; p < 20; p++) w[p] = cap[(19 - p) * RCOUNT + a];
      return w;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      for (int b = 0; b < 2; b++)
         for (int a = 0; a < DEPTH; a++) model[b][a] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(ser_valid == 1'b0, "R11 ser_valid after reset", int'(ser_valid), 0);
      check(frame_err == 1'b0, "R11 frame_err after reset", int'(frame_err), 0);
      check(host_ready == 1'b1, "R11 host_ready after reset", int'(host_ready), 1);

      // frame A into bank 0
      for (int i = 0; i < 8; i++) send_record(VEC[i]);
      check(host_ready == 1'b0, "R5 ready low after last word", int'(host_ready), 0);
      pulse_tick();
      fill = 1;
      check(host_ready == 1'b1, "R5 ready back after tick", int'(host_ready), 1);

      fork
         collect();
         begin
            send_word(12'h0AB);
            check(frame_err == 1'b1, "R4 orphan first word", int'(frame_err), 1);
            @(negedge clk);
            check(frame_err == 1'b0, "R4 error is one cycle", int'(frame_err), 0);
            send_word(12'h9FF);
            send_word(12'h801);
            check(frame_err == 1'b1, "R4 start flag cuts group", int'(frame_err), 1);
            send_word(12'h0FF);
            send_word(12'h009);
            model[1][9] = stored({10'h001, 9'h0FF});
            for (int i = 8; i < NVEC; i++) send_record(VEC[i]);
            repeat (40) @(negedge clk);
            check(ser_valid == 1'b1, "R10 tick lands inside read-out", int'(ser_valid), 1);
            pulse_tick();
            @(negedge clk);
            check(host_ready == 1'b0, "R10 ignored tick keeps intake closed", int'(host_ready), 0);
         end
      join

      check(cap_n == NBITS, "R7 R8 frame A bit count", cap_n, NBITS);
      check(stream_diff(0) == 0, "R1 R2 R7 frame A stream", stream_diff(0), 0);
      check(word_at(8) == 20'h0, "R3 out-of-depth record dropped", int'(word_at(8)), 0);
      check(word_at(5) == stored(19'h00F0F), "R3 overwrite keeps later word",
            int'(word_at(5)), int'(stored(19'h00F0F)));
      check(word_at(12) == 20'h00001, "R2 all-zero data gets parity one",
            int'(word_at(12)), 1);
      for (int a = 0; a < RCOUNT; a++) model[0][a] = '0;

      // frame B from bank 1
      pulse_tick();
      fill = 0;
      collect();
      check(cap_n == NBITS, "R7 frame B bit count", cap_n, NBITS);
      check(stream_diff(1) == 0, "R6 frame B from other bank", stream_diff(1), 0);
      check(word_at(9) == stored({10'h001, 9'h0FF}), "R4 restarted group stored",
            int'(word_at(9)), int'(stored({10'h001, 9'h0FF})));
      for (int a = 0; a < RCOUNT; a++) model[1][a] = '0;

      // bank 0 again with no new writes
      pulse_tick();
      fill = 1;
      collect();
      check(cap_n == NBITS, "R9 frame C bit count", cap_n, NBITS);
      check(stream_diff(0) == 0, "R9 cleared bank sends zeros", stream_diff(0), 0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule